// File: doc/BRIEF.md
# Selectable Biased Unbiased Rounder

This block takes a 40-bit multiply-accumulate value and rounds it to the precision of its upper 24 bits. The value is split into an 8-bit overflow field, a 16-bit high word and a 16-bit low word. The low word decides whether the upper 24 bits are incremented. The low word itself is passed through unchanged. The rounded value appears one clock after a strobe on the input, together with a valid flag.

A single mode bit selects the rounding rule, and it is held in a 16-bit control register with its own write port. The two rules give different results only when the low word is exactly at the halfway code 0x8000. In the half-even rule, a tie makes the high word even. In the half-up rule, a tie always rounds up. Every other low word is handled the same way in both modes.

The mode register acts as a two-state machine with the states RND_HALF_EVEN and RND_HALF_UP. A write that carries a 1 in the mode bit moves it to RND_HALF_UP. A write that carries a 0 moves it to RND_HALF_EVEN. When there is no write, the state holds. Reset forces RND_HALF_EVEN.

Top module: `mac_rounder`

## Requirements
- R1: After reset, out_valid is 0, out_acc is 0 and the rounding mode is half-even (unbiased).
- R2: A cycle with cfg_we high loads the mode from bit 12 of cfg_wdata: 0 selects half-even and 1 selects half-up. All other bits of cfg_wdata have no effect on any result.
- R3: In both modes, a low word (bits 15:0) above 0x8000 increments the upper 24 bits (bits 39:16) by one. A low word below 0x8000 leaves them unchanged.
- R4: In half-even mode, a low word of exactly 0x8000 increments the upper 24 bits only when bit 16 is 1. When bit 16 is 0, the upper 24 bits are unchanged, so the result's bit 16 is always 0.
- R5: In half-up mode, a low word of exactly 0x8000 always increments the upper 24 bits. For example, 0x00_0000_8000 gives 0x00_0001_8000, and 0x00_0001_8000 gives 0x00_0002_8000.
- R6: Bits 15:0 of the result equal bits 15:0 of the input.
- R7: A carry out of the high word enters the overflow field. The sum wraps modulo 2^40 without saturating, so 0xFF_FFFF_xxxx rounded up gives 0x00_0000_xxxx.
- R8: out_valid is in_valid delayed by exactly one clock. out_acc is loaded only on cycles with in_valid high and holds otherwise.
- R9: A sample presented in the same cycle as a control write is rounded with the mode that was in force before the write. The new mode applies from the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Strobe marking a sample on in_acc |
| in_acc | input | 40 | Value to round: overflow field, high word and low word |
| cfg_we | input | 1 | Control register write enable |
| cfg_wdata | input | 16 | Control register write data; bit 12 is the mode |
| out_valid | output | 1 | Result valid, one clock after in_valid |
| out_acc | output | 40 | Rounded value |

## Verification
A control-register write and a rounding sample can land in the same clock edge. The bench provokes this by raising cfg_we, with a changed mode bit, in the same cycle that it strobes a tie sample of 0x00_0000_8000. The result must follow the old mode. The next identical sample must follow the new mode. Around this case, sweeps over both modes, many high-word patterns and a broad low-word grid compare every result against an arithmetic model, with extra attention on the tie code and on wrap-around.

// File: rtl/rnd_pkg.sv
package rnd_pkg;

    typedef enum logic {
        RND_HALF_EVEN = 1'b0,
        RND_HALF_UP   = 1'b1
    } rnd_mode_e;

endpackage

// File: rtl/rnd_mode_reg.sv
module rnd_mode_reg
    import rnd_pkg::*;
#(
    parameter int CFG_W    = 16,
    parameter int MODE_BIT = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    output rnd_mode_e        mode_o
);

    rnd_mode_e mode_q, mode_d;
    logic      unused_cfg;

    assign unused_cfg = ^(cfg_wdata & ~(CFG_W'(1) << MODE_BIT));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= RND_HALF_EVEN;
        else        mode_q <= mode_d;
    end

    always_comb begin
        mode_d = mode_q;
        if (cfg_we) begin
            unique case (cfg_wdata[MODE_BIT])
                1'b0: mode_d = RND_HALF_EVEN;
                1'b1: mode_d = RND_HALF_UP;
                default: mode_d = mode_q;
            endcase
        end
    end

    assign mode_o = mode_q;

endmodule

// File: rtl/rnd_decide.sv
module rnd_decide
    import rnd_pkg::*;
#(
    parameter int LO_W = 16
) (
    input  logic [LO_W-1:0] lo,
    input  logic            upper_lsb,
    input  rnd_mode_e       mode,
    output logic            inc
);

    localparam logic [LO_W-1:0] HALF = {1'b1, {(LO_W-1){1'b0}}};

    logic tie_up;

    always_comb begin
        unique case (mode)
            RND_HALF_EVEN: tie_up = upper_lsb;
            RND_HALF_UP:   tie_up = 1'b1;
            default:       tie_up = 1'b0;
        endcase
    end

    assign inc = (lo > HALF) || ((lo == HALF) && tie_up);

endmodule

// File: rtl/rnd_out_stage.sv
module rnd_out_stage #(
    parameter int UP_W = 24,
    parameter int LO_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [UP_W-1:0]      upper,
    input  logic                 inc,
    input  logic [LO_W-1:0]      lo,
    output logic                 out_valid,
    output logic [UP_W+LO_W-1:0] out_acc
);

    logic [UP_W-1:0] upper_rnd;

    assign upper_rnd = upper + UP_W'(inc);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_acc   <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) out_acc <= {upper_rnd, lo};
        end
    end

endmodule

// File: rtl/mac_rounder.sv
module mac_rounder
    import rnd_pkg::*;
#(
    parameter int OVF_W    = 8,
    parameter int HI_W     = 16,
    parameter int LO_W     = 16,
    parameter int CFG_W    = 16,
    parameter int MODE_BIT = 12
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_valid,
    input  logic [OVF_W+HI_W+LO_W-1:0]    in_acc,
    input  logic                          cfg_we,
    input  logic [CFG_W-1:0]              cfg_wdata,
    output logic                          out_valid,
    output logic [OVF_W+HI_W+LO_W-1:0]    out_acc
);

    localparam int ACC_W = OVF_W + HI_W + LO_W;
    localparam int UP_W  = OVF_W + HI_W;

    rnd_mode_e       mode;
    logic [UP_W-1:0] upper;
    logic [LO_W-1:0] lo;
    logic            inc;

    assign upper = in_acc[ACC_W-1:LO_W];
    assign lo    = in_acc[LO_W-1:0];

    rnd_mode_reg #(.CFG_W(CFG_W), .MODE_BIT(MODE_BIT)) u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .mode_o    (mode)
    );

    rnd_decide #(.LO_W(LO_W)) u_decide (
        .lo        (lo),
        .upper_lsb (upper[0]),
        .mode      (mode),
        .inc       (inc)
    );

    rnd_out_stage #(.UP_W(UP_W), .LO_W(LO_W)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .upper     (upper),
        .inc       (inc),
        .lo        (lo),
        .out_valid (out_valid),
        .out_acc   (out_acc)
    );

endmodule

// File: rtl/mac_rounder_checker.sv
module mac_rounder_checker #(
    parameter int OVF_W    = 8,
    parameter int HI_W     = 16,
    parameter int LO_W     = 16,
    parameter int CFG_W    = 16,
    parameter int MODE_BIT = 12
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       in_valid,
    input logic [OVF_W+HI_W+LO_W-1:0] in_acc,
    input logic                       cfg_we,
    input logic [CFG_W-1:0]           cfg_wdata,
    input logic                       out_valid,
    input logic [OVF_W+HI_W+LO_W-1:0] out_acc
);

    localparam int ACC_W = OVF_W + HI_W + LO_W;
    localparam int UP_W  = OVF_W + HI_W;
    localparam logic [LO_W-1:0] HALF = {1'b1, {(LO_W-1){1'b0}}};

    logic            half_up_q;
    logic [UP_W-1:0] prev_up;
    logic [UP_W-1:0] step;
    logic            unused_chk;

    assign unused_chk = ^(cfg_wdata & ~(CFG_W'(1) << MODE_BIT));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            half_up_q <= 1'b0;
            prev_up   <= '0;
        end else begin
            if (cfg_we)   half_up_q <= cfg_wdata[MODE_BIT];
            if (in_valid) prev_up   <= in_acc[ACC_W-1:LO_W];
        end
    end

    assign step = out_acc[ACC_W-1:LO_W] - prev_up;

    assert_valid_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_valid_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_acc));
    assert_low_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_acc[LO_W-1:0] == $past(in_acc[LO_W-1:0]));
    assert_above_half_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_acc[LO_W-1:0] > HALF) |=> step == UP_W'(1));
    assert_below_half_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_acc[LO_W-1:0] < HALF) |=> step == '0);
    assert_tie_up_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_acc[LO_W-1:0] == HALF && half_up_q) |=> step == UP_W'(1));
    assert_tie_even_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_acc[LO_W-1:0] == HALF && !half_up_q)
        |=> (out_acc[LO_W] == 1'b0 && step <= UP_W'(1)));
    assert_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && &in_acc[ACC_W-1:LO_W] && in_acc[LO_W-1:0] > HALF)
        |=> out_acc[ACC_W-1:LO_W] == '0);

endmodule

bind mac_rounder mac_rounder_checker #(
    .OVF_W(OVF_W), .HI_W(HI_W), .LO_W(LO_W), .CFG_W(CFG_W), .MODE_BIT(MODE_BIT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_acc    (in_acc),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .out_valid (out_valid),
    .out_acc   (out_acc)
);

// File: tb/mac_rounder_test.sv
module mac_rounder_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [39:0] in_acc = '0;
    logic        cfg_we = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic        out_valid;
    logic [39:0] out_acc;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;
    bit done = 1'b0;
    bit mode_up = 1'b0;

    always #10 clk = ~clk;

    mac_rounder uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_acc    (in_acc),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .out_valid (out_valid),
        .out_acc   (out_acc)
    );

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            summary();
            $finish;
        end
    end

    function automatic logic [39:0] model(bit up, logic [23:0] hi, logic [15:0] lo);
        bit inc;
        inc = (lo > 16'h8000) || (lo == 16'h8000 && (up || hi[0]));
        return {hi + 24'(inc), lo};
    endfunction

    task automatic chk(string req, logic [39:0] act, logic [39:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic write_cfg(logic [15:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        mode_up = d[12];
    endtask

    task automatic one(string req, logic [23:0] hi, logic [15:0] lo);
        @(negedge clk);
        in_valid = 1'b1; in_acc = {hi, lo};
        @(negedge clk);
        in_valid = 1'b0;
        chk({req, " valid R8"}, {39'd0, out_valid}, 40'd1);
        chk(req, out_acc, model(mode_up, hi, lo));
    endtask

    task automatic sweep(bit up);
        logic [23:0] his [8];
        his = '{24'h000000, 24'h000001, 24'h000002, 24'h000003,
                24'h00FFFF, 24'h7F1234, 24'hFFFFFE, 24'hFFFFFF};
        for (int h = 0; h < 8; h++) begin
            for (int i = 0; i < 256; i++) begin
                logic [15:0] lo;
                lo = 16'(i * 257);
                one(lo > 16'h8000 ? "R3_above" : (lo < 16'h8000 ? "R3_below" : "R4_R5_tie"), his[h], lo);
            end
            one("R3_R6_under", his[h], 16'h7FFF);
            one(up ? "R5_tie" : "R4_tie", his[h], 16'h8000);
            one("R3_R7_over", his[h], 16'h8001);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 out_valid", {39'd0, out_valid}, 40'd0);
        chk("R1 out_acc", out_acc, 40'd0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: mode after reset is half-even, tie on even word stays put
        mode_up = 1'b0;
        one("R1_mode", 24'h000000, 16'h8000);
        chk("R1 tie even", out_acc, 40'h00_0000_8000);

        sweep(1'b0);

        // R2: only bit 12 counts
        write_cfg(16'h1000);
        one("R2_set", 24'h000000, 16'h8000);
        chk("R5 example a", out_acc, 40'h00_0001_8000);
        one("R5_ex", 24'h000001, 16'h8000);
        chk("R5 example b", out_acc, 40'h00_0002_8000);
        write_cfg(16'hEFFF);
        one("R2_others", 24'h000000, 16'h8000);
        chk("R2 other bits ignored", out_acc, 40'h00_0000_8000);
        write_cfg(16'h1000);

        sweep(1'b1);

        // R7 explicit wrap
        one("R7_wrap", 24'hFFFFFF, 16'h8000);
        chk("R7 wrap", out_acc, 40'h00_0000_8000);

        // R8: idle cycle holds out_acc and drops out_valid
        @(negedge clk);
        chk("R8 idle valid", {39'd0, out_valid}, 40'd0);
        chk("R8 hold", out_acc, 40'h00_0000_8000);

        // R9: write to half-even in same cycle as tie sample; old mode (half-up) applies
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = 16'h0000;
        in_valid = 1'b1; in_acc = 40'h00_0000_8000;
        @(negedge clk);
        cfg_we = 1'b0; in_valid = 1'b0;
        chk("R9 old mode", out_acc, 40'h00_0001_8000);
        mode_up = 1'b0;
        one("R9_new", 24'h000000, 16'h8000);
        chk("R9 new mode", out_acc, 40'h00_0000_8000);

        // R9 other direction
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = 16'h1000;
        in_valid = 1'b1; in_acc = 40'h00_0002_8000;
        @(negedge clk);
        cfg_we = 1'b0; in_valid = 1'b0;
        chk("R9 old even", out_acc, 40'h00_0002_8000);
        mode_up = 1'b1;
        one("R9_new_up", 24'h000002, 16'h8000);
        chk("R9 new up", out_acc, 40'h00_0003_8000);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule